// File: doc/BRIEF.md
# Conditional Skip Test Evaluator

This block judges the test-and-skip instructions of a small 4-bit processor. Each cycle the sequencer may present one instruction byte together with the operands that byte can test: the carry flag, the accumulator, the data nibble at the current memory pointer, and the 4-bit general-purpose port register. When the byte finishes a test instruction, the block raises a skip request for the following instruction if the tested condition holds.

Tests are either one byte long or two bytes long. A two-byte test begins with the escape byte 0x33. The block keeps a registered flag that marks the byte after that escape byte. Under that flag, the bit-select codes and 0x21 test the port register. Without it, the same codes test the memory nibble or compare the accumulator with memory.

A sticky flag records whether the external time-base counter has carried since the timer test last ran. The timer test reads this flag and clears it. The time-base counter, the memory and the sequencer are not part of this block.

Top module: `skip_test_eval`

## Requirements
- R1: After reset, skip_req is 0, no escape byte is pending, and the timer flag is clear, so a timer test (0x41) issued right after reset does not skip.
- R2: Byte 0x20 without a pending escape requests a skip exactly when carry_in is 1.
- R3: Byte 0x21 without a pending escape requests a skip exactly when acc equals mem_nib.
- R4: Byte 0x21 following the escape byte 0x33 requests a skip exactly when all four bits of port_g are 0.
- R5: A bit code following 0x33 requests a skip exactly when the selected port_g bit is 0. The bit codes are 0x01 for bit 0, 0x11 for bit 1, 0x03 for bit 2 and 0x13 for bit 3, so the bit index is {byte[1], byte[4]}.
- R6: The same bit codes without a pending escape request a skip exactly when the selected mem_nib bit is 0.
- R7: Byte 0x41 without a pending escape requests a skip exactly when the timer flag is set. A tb_carry pulse sets the flag, and executing 0x41 clears it.
- R8: A tb_carry pulse in the same cycle as an executing 0x41 leaves the flag set, so the next 0x41 skips.
- R9: The escape byte 0x33 never requests a skip. Any valid byte that follows it is consumed as the second byte and clears the pending escape. A second byte that is not a port test requests no skip. Cycles with instr_valid low keep the escape pending.
- R10: skip_req rises in the cycle after the completing byte is presented, and only for one cycle. Cycles with instr_valid low, and bytes that are not tests, never produce a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction byte is presented this cycle |
| instr_byte | input | 8 | Instruction byte |
| carry_in | input | 1 | Processor carry flag |
| acc | input | 4 | Accumulator |
| mem_nib | input | 4 | Memory nibble at the current pointer |
| port_g | input | 4 | General-purpose port register |
| tb_carry | input | 1 | One-cycle pulse when the time-base counter carries |
| skip_req | output | 1 | Registered skip request for the next instruction |

## Verification
Every skip result is registered once. The bench drives a byte and its operands on a falling edge, lets one rising edge pass, and reads skip_req at the next falling edge. That is exactly one cycle after the stimulus, and the next stimulus is applied at that same falling edge.

The escape flag and the timer flag also change on that rising edge. The bench updates its own copies of both in the same step, so its expectation for the following byte already reflects them. Cases spanning several cycles, such as an escape byte followed by idle cycles or a carry pulse arriving together with a timer test, are checked only at the cycle where the completing byte's result is due.

// File: rtl/skip_test_pkg.sv
package skip_test_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned IDX_W  = $clog2(NIB_W);

  localparam logic [BYTE_W-1:0] OP_ESCAPE = 8'h33;
  localparam logic [BYTE_W-1:0] OP_CARRY  = 8'h20;
  localparam logic [BYTE_W-1:0] OP_EQUAL  = 8'h21;
  localparam logic [BYTE_W-1:0] OP_TIMER  = 8'h41;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_CARRY,
    TK_EQUAL,
    TK_GZERO,
    TK_GBIT,
    TK_MBIT,
    TK_TIMER
  } test_kind_e;

  typedef struct packed {
    test_kind_e       kind;
    logic [IDX_W-1:0] bit_idx;
    logic             is_escape;
  } decoded_t;

  // bit codes: 0x01, 0x11, 0x03, 0x13 -> index {b[1], b[4]}
  function automatic logic is_bit_code(input logic [BYTE_W-1:0] b);
    return (b[7:5] == 3'b000) && (b[3:2] == 2'b00) && b[0];
  endfunction
endpackage

// File: rtl/skip_decode.sv
module skip_decode
  import skip_test_pkg::*;
(
  input  logic              valid,
  input  logic [BYTE_W-1:0] op,
  input  logic              escaped,
  output decoded_t          dec
);
  logic bitc;
  logic sel_carry, sel_equal, sel_gzero, sel_gbit, sel_mbit, sel_timer, sel_esc;

  always_comb begin
    bitc      = is_bit_code(op);
    sel_esc   = valid && !escaped && (op == OP_ESCAPE);
    sel_carry = valid && !escaped && (op == OP_CARRY);
    sel_equal = valid && !escaped && (op == OP_EQUAL);
    sel_timer = valid && !escaped && (op == OP_TIMER);
    sel_mbit  = valid && !escaped && bitc;
    sel_gzero = valid &&  escaped && (op == OP_EQUAL);
    sel_gbit  = valid &&  escaped && bitc;

    dec.is_escape = sel_esc;
    dec.bit_idx   = {op[1], op[4]};
    if      (sel_carry) dec.kind = TK_CARRY;
    else if (sel_equal) dec.kind = TK_EQUAL;
    else if (sel_gzero) dec.kind = TK_GZERO;
    else if (sel_gbit)  dec.kind = TK_GBIT;
    else if (sel_mbit)  dec.kind = TK_MBIT;
    else if (sel_timer) dec.kind = TK_TIMER;
    else                dec.kind = TK_NONE;
  end

  // R10: at most one test meaning per byte
  always_comb begin
    assert_decode_unique_R10: assert ($onehot0({sel_carry, sel_equal, sel_gzero,
                                                sel_gbit, sel_mbit, sel_timer, sel_esc}));
  end
endmodule

// File: rtl/skip_timer_flag.sv
module skip_timer_flag (
  input  logic clk,
  input  logic rst,
  input  logic carry_pulse,
  input  logic consume,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)              flag_q <= 1'b0;
    else if (carry_pulse) flag_q <= 1'b1;
    else if (consume)     flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R7 / R8: a pulse always leaves the flag set, even while it is being consumed
  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (rst)
    carry_pulse |=> flag_q);
  // R7: consuming without a new pulse clears it
  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (consume && !carry_pulse) |=> !flag_q);
endmodule

// File: rtl/skip_cond.sv
module skip_cond
  import skip_test_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  decoded_t          dec,
  input  logic              carry,
  input  logic [W-1:0]      acc,
  input  logic [W-1:0]      mem,
  input  logic [W-1:0]      gport,
  input  logic              timer_flag,
  output logic              take
);
  always_comb begin
    unique case (dec.kind)
      TK_CARRY: take = carry;
      TK_EQUAL: take = (acc == mem);
      TK_GZERO: take = (gport == '0);
      TK_GBIT:  take = !gport[dec.bit_idx];
      TK_MBIT:  take = !mem[dec.bit_idx];
      TK_TIMER: take = timer_flag;
      default:  take = 1'b0;
    endcase
  end
endmodule

// File: rtl/skip_test_eval.sv
module skip_test_eval
  import skip_test_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [BYTE_W-1:0] instr_byte,
  input  logic              carry_in,
  input  logic [NIB_W-1:0]  acc,
  input  logic [NIB_W-1:0]  mem_nib,
  input  logic [NIB_W-1:0]  port_g,
  input  logic              tb_carry,
  output logic              skip_req
);
  decoded_t dec;
  logic     escape_q;
  logic     skip_q;
  logic     timer_flag;
  logic     take;

  skip_decode u_dec (
    .valid   (instr_valid),
    .op      (instr_byte),
    .escaped (escape_q),
    .dec     (dec)
  );

  skip_timer_flag u_tmr (
    .clk         (clk),
    .rst         (rst),
    .carry_pulse (tb_carry),
    .consume     (dec.kind == TK_TIMER),
    .flag        (timer_flag)
  );

  skip_cond #(.W(NIB_W)) u_cond (
    .dec        (dec),
    .carry      (carry_in),
    .acc        (acc),
    .mem        (mem_nib),
    .gport      (port_g),
    .timer_flag (timer_flag),
    .take       (take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      escape_q <= 1'b0;
      skip_q   <= 1'b0;
    end else begin
      if (instr_valid) escape_q <= dec.is_escape;
      skip_q <= take;
    end
  end

  assign skip_req = skip_q;

  // R9: the escape byte itself never yields a skip
  assert_escape_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    escape_q |-> !skip_q);
  // R10: a skip always traces back to a presented byte
  assert_skip_needs_byte_R10: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> $past(instr_valid));
  // R4: a nonzero port never passes the all-zero test
  assert_gzero_R4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && escape_q && instr_byte == OP_EQUAL && port_g != '0) |=> !skip_q);
  // R9: idle cycles keep a pending escape
  assert_escape_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (escape_q && !instr_valid) |=> escape_q);
endmodule

// File: tb/skip_test_eval_test.sv
`timescale 1ns/1ps
module skip_test_eval_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       instr_valid;
  logic [7:0] instr_byte;
  logic       carry_in;
  logic [3:0] acc, mem_nib, port_g;
  logic       tb_carry;
  logic       skip_req;

  int checks = 0;
  int fails  = 0;
  logic m_esc  = 1'b0;
  logic m_flag = 1'b0;
  logic done   = 1'b0;

  always #2 clk = ~clk;

  skip_test_eval uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_byte(instr_byte),
    .carry_in(carry_in), .acc(acc), .mem_nib(mem_nib), .port_g(port_g),
    .tb_carry(tb_carry), .skip_req(skip_req)
  );

  function automatic logic bitcode(input logic [7:0] b);
    return (b == 8'h01) || (b == 8'h11) || (b == 8'h03) || (b == 8'h13);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: skip_req=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; result is checked one falling edge later
  task automatic step(input logic v, input logic [7:0] b, input logic c,
                      input logic [3:0] a, input logic [3:0] m,
                      input logic [3:0] g, input logic p);
    logic  exp;
    string req;
    logic [1:0] idx;
    idx = {b[1], b[4]};
    exp = 1'b0;
    req = "R10";
    instr_valid = v; instr_byte = b; carry_in = c;
    acc = a; mem_nib = m; port_g = g; tb_carry = p;
    if (v) begin
      if (m_esc) begin
        if (b == 8'h21)      begin exp = (g == 4'h0); req = "R4"; end
        else if (bitcode(b)) begin exp = !g[idx];     req = "R5"; end
        else                 req = "R9";
        m_esc = 1'b0;
        m_flag = m_flag | p;
      end else begin
        if (b == 8'h33)      begin m_esc = 1'b1; req = "R9"; end
        else if (b == 8'h20) begin exp = c;        req = "R2"; end
        else if (b == 8'h21) begin exp = (a == m); req = "R3"; end
        else if (bitcode(b)) begin exp = !m[idx];  req = "R6"; end
        else if (b == 8'h41) begin exp = m_flag;   req = p ? "R8" : "R7"; end
        if (b == 8'h41) m_flag = p;
        else            m_flag = m_flag | p;
      end
    end else begin
      m_flag = m_flag | p;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, skip_req, exp);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [10];
    ops = '{8'h20, 8'h21, 8'h33, 8'h01, 8'h11, 8'h03, 8'h13, 8'h41, 8'h00, 8'h5A};
    void'($urandom(32'h5EED1234));
    rst = 1'b1;
    instr_valid = 0; instr_byte = 0; carry_in = 0;
    acc = 0; mem_nib = 0; port_g = 0; tb_carry = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", skip_req, 1'b0);
    // R1: timer flag clear after reset
    step(1, 8'h41, 0, 0, 0, 0, 0);
    // R2
    step(1, 8'h20, 1, 0, 0, 0, 0);
    step(1, 8'h20, 0, 0, 0, 0, 0);
    // R3
    step(1, 8'h21, 0, 4'h9, 4'h9, 0, 0);
    step(1, 8'h21, 0, 4'h9, 4'h8, 0, 0);
    // R4 with idle cycles between escape and second byte (R9 hold)
    step(1, 8'h33, 1, 4'h3, 4'h3, 4'h0, 0);
    idle(); idle();
    step(1, 8'h21, 0, 4'h3, 4'h3, 4'h0, 0);
    step(1, 8'h33, 0, 0, 0, 4'h8, 0);
    step(1, 8'h21, 0, 4'h3, 4'h3, 4'h8, 0);
    // R5: each port bit, zero and one; memory all ones so R6 meaning would differ
    for (int i = 0; i < 4; i++) begin
      logic [7:0] bc;
      bc = (i == 0) ? 8'h01 : (i == 1) ? 8'h11 : (i == 2) ? 8'h03 : 8'h13;
      step(1, 8'h33, 0, 0, 0, 0, 0);
      step(1, bc, 0, 0, 4'hF, ~(4'h1 << i), 0);
      step(1, 8'h33, 0, 0, 0, 0, 0);
      step(1, bc, 0, 0, 4'h0, 4'h1 << i, 0);
      // R6
      step(1, bc, 0, 0, ~(4'h1 << i), 4'hF, 0);
      step(1, bc, 0, 0, 4'h1 << i, 4'h0, 0);
    end
    // R9: escape then a non-port-test byte is consumed, no skip
    step(1, 8'h33, 0, 0, 0, 0, 0);
    step(1, 8'h20, 1, 0, 0, 0, 0);
    step(1, 8'h20, 1, 0, 0, 0, 0);
    // R7 / R8
    step(0, 8'h00, 0, 0, 0, 0, 1);
    step(1, 8'h41, 0, 0, 0, 0, 0);
    step(1, 8'h41, 0, 0, 0, 0, 0);
    step(1, 8'h41, 0, 0, 0, 0, 1);
    step(1, 8'h41, 0, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0, 1);
    step(1, 8'h41, 0, 0, 0, 0, 1);
    step(1, 8'h41, 0, 0, 0, 0, 0);
    // R10: invalid cycles with test bytes never skip
    step(0, 8'h20, 1, 0, 0, 0, 0);
    step(0, 8'h01, 0, 0, 0, 0, 0);
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] b;
      logic [3:0] a, m, g;
      b = ops[$urandom % 10];
      a = 4'($urandom); m = ($urandom % 3 == 0) ? a : 4'($urandom);
      g = ($urandom % 3 == 0) ? 4'h0 : 4'($urandom);
      step(($urandom % 5) != 0, b, 1'($urandom), a, m, g, ($urandom % 6) == 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule